// File: doc/BRIEF.md
# Mismatch Bit Priority Encoder

The block compares two equal-width words position by position. Each position where the two words disagree raises a request. Among these requests the most significant one wins, and it is reported as a one-hot vector. A separate flag shows that the two words agree in every position.

A parameter sets the word width (default 4). A second parameter picks between two variants. The combinational variant drives the outputs straight from the inputs. The registered variant captures a result one clock after the valid input is high and holds it until the next valid. A valid output marks the cycle after each capture.

Top module: `mismatch_prio_enc`

## Requirements
- R1: Bit i of the request vector is the exclusive-OR of `wordA[i]` and `wordB[i]`.
- R2: `hitOneHot[W-1]` is 1 whenever the two top bits differ, whatever the lower positions hold.
- R3: `hitOneHot[i]` for i below W-1 is 1 only when position i differs and every position above i matches.
- R4: `hitOneHot` has at most one bit set at any time.
- R5: When the words are equal, `hitOneHot` is all zeros and `allMatch` is 1. Otherwise `allMatch` is 0.
- R6: In the registered variant (REGISTERED=1), `hitOneHot` and `allMatch` show the result for the inputs sampled at the clock edge where `inValid` is 1. They keep that result while `inValid` is 0. `outValid` is 1 in the cycle that follows each accepted input.
- R7: In the registered variant, reset clears `hitOneHot` to 0, sets `allMatch` to 1 and clears `outValid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered variant) |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input words are valid this cycle |
| wordA | input | W | First word |
| wordB | input | W | Second word |
| hitOneHot | output | W | One-hot marker of the highest differing position |
| allMatch | output | 1 | The words are equal |
| outValid | output | 1 | A new result was captured on the previous edge |

## Verification
All 256 pairs of 4-bit words run through the registered variant. Each result is compared with a reference that scans the positions from the top down. A second instance in the combinational variant is checked against the same reference. Directed patterns cover four cases:
- equal words, which exercise the flag;
- a difference only at the top bit, with the lower bits set in random ways, which shows that the top bit wins;
- a single difference in the lowest bit, which reaches the last priority level;
- an idle period with `inValid` low and different inputs, which shows that the held result does not move.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  typedef struct packed {
    logic capture;
    logic clear;
  } mpeStrobe_t;
endpackage

// File: rtl/mpe_ctrl.sv
module mpe_ctrl
  import mpe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output mpeStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.clear   = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/mpe_datapath.sv
module mpe_datapath
  import mpe_pkg::*;
#(
  parameter int W = 4,
  parameter bit REGISTERED = 1'b1
)(
  input  logic         clk,
  input  logic         rstN,
  input  mpeStrobe_t   strobe,
  input  logic [W-1:0] wordA,
  input  logic [W-1:0] wordB,
  output logic [W-1:0] hitOneHot,
  output logic         allMatch
);
  localparam int TOP = W - 1;

  logic [W-1:0] req;
  logic [W-1:0] higherSeen;
  logic [W-1:0] hitNext;
  logic         matchNext;

  assign req = wordA ^ wordB;

  // Each position wins only when nothing above it has a request.
  assign higherSeen[TOP] = 1'b0;
  genvar gi;
  generate
    for (gi = TOP - 1; gi >= 0; gi--) begin : g_chain
      assign higherSeen[gi] = higherSeen[gi+1] | req[gi+1];
    end
  endgenerate

  assign hitNext   = req & ~higherSeen;
  assign matchNext = ~|req;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hitOneHot <= '0;
          allMatch  <= 1'b1;
        end else if (strobe.clear) begin
          hitOneHot <= '0;
          allMatch  <= 1'b1;
        end else if (strobe.capture) begin
          hitOneHot <= hitNext;
          allMatch  <= matchNext;
        end
      end

      p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capture |=> $stable(hitOneHot) && $stable(allMatch));
      p_top_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture && (wordA[TOP] != wordB[TOP])) |=> hitOneHot[TOP]);
    end else begin : g_comb
      assign hitOneHot = hitNext;
      assign allMatch  = matchNext;
    end
  endgenerate

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitOneHot));
  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    allMatch |-> (hitOneHot == '0));
  p_flag_need_r5: assert property (@(posedge clk) disable iff (!rstN)
    !allMatch |-> ($countones(hitOneHot) == 1));
endmodule

// File: rtl/mismatch_prio_enc.sv
module mismatch_prio_enc
  import mpe_pkg::*;
#(
  parameter int W = 4,
  parameter bit REGISTERED = 1'b1
)(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] wordA,
  input  logic [W-1:0] wordB,
  output logic [W-1:0] hitOneHot,
  output logic         allMatch,
  output logic         outValid
);
  mpeStrobe_t strobe;

  mpe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  mpe_datapath #(.W(W), .REGISTERED(REGISTERED)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wordA(wordA), .wordB(wordB),
    .hitOneHot(hitOneHot), .allMatch(allMatch)
  );
endmodule

// File: tb/sim_mismatch_prio_enc.sv
module sim_mismatch_prio_enc;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] wordA = '0, wordB = '0;
  logic [W-1:0] hitOneHot, hitComb;
  logic allMatch, outValid, matchComb, outValidComb;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mismatch_prio_enc #(.W(W), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wordA(wordA), .wordB(wordB),
    .hitOneHot(hitOneHot), .allMatch(allMatch), .outValid(outValid));

  mismatch_prio_enc #(.W(W), .REGISTERED(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wordA(wordA), .wordB(wordB),
    .hitOneHot(hitComb), .allMatch(matchComb), .outValid(outValidComb));

  function automatic logic [W-1:0] refHit(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (a[i] != b[i]) begin
        r[i] = 1'b1;
        break;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One accepted input: drive after the falling edge, sample after the next falling edge.
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    wordA = a; wordB = b; inValid = 1'b1;
    #1;
    check("R1/R3 comb hit", hitComb, refHit(a, b));
    check("R5 comb flag", matchComb, a == b);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 reset hit", hitOneHot, 0);
    check("R7 reset flag", allMatch, 1);
    check("R7 reset valid", outValid, 0);
    rstN = 1'b1;
  endtask

  task automatic testExhaustive();
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] a, b;
      a = v[7:4]; b = v[3:0];
      apply(a, b);
      check("R6 valid", outValid, 1);
      check("R3 hit", hitOneHot, refHit(a, b));
      check("R5 flag", allMatch, a == b);
      check("R4 onehot", $countones(hitOneHot) <= 1, 1);
    end
  endtask

  task automatic testTopWins();
    for (int lo = 0; lo < 8; lo++) begin
      apply(4'b1000 | lo[3:0], 4'b0000 | (~lo[3:0] & 4'b0111));
      check("R2 top wins", hitOneHot, 4'b1000);
      check("R2 flag", allMatch, 0);
    end
  endtask

  task automatic testLowest();
    apply(4'b1011, 4'b1010);
    check("R3 lowest", hitOneHot, 4'b0001);
    apply(4'b0110, 4'b0110);
    check("R5 equal hit", hitOneHot, 0);
    check("R5 equal flag", allMatch, 1);
  endtask

  task automatic testHold();
    apply(4'b0100, 4'b0000);
    @(negedge clk);
    wordA = 4'b1000; wordB = 4'b0000;
    repeat (3) @(negedge clk);
    check("R6 hold hit", hitOneHot, 4'b0100);
    check("R6 hold flag", allMatch, 0);
    check("R6 valid low", outValid, 0);
  endtask

  initial begin
    testReset();
    testExhaustive();
    testTopWins();
    testLowest();
    testHold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule